// File: doc/BRIEF.md
# Flyback Switch Cycle Controller

This block produces the gate command for the primary switch of a flyback converter that charges a large output capacitor. It works from comparator results that have already been digitized: a peak-current flag, a flag that goes high once secondary conduction has stopped (the transformer flux is reset), and a flag that goes high once the output has reached its target. All timing comes from cycle counters on a fixed clock. At the default 100 MHz the on and off watchdogs are 1800 cycles (18 µs), and the two minimum off pulses are 20 and 40 cycles.

Charging starts in timer mode. In this mode every off interval runs for the full off watchdog, which limits the inrush current while the output voltage is still low. Once flux reset has been seen in time on consecutive off intervals, the controller moves to fast-charging mode. In fast-charging mode the next on interval begins as soon as a valid flux-reset flag arrives. When the output target is reached, switching stops for the rest of the session. A new session starts only after the enable input has been taken low and raised again.

Top module: `flyback_cycle_ctrl`

## Requirements
- R1: While `enable` is low, `gateOn` and `fastMode` are low and the on/off counters and mode history are cleared. When `enable` is raised again, the controller restarts in timer mode.
- R2: Starting from idle with `targetReached` low, `gateOn` goes high on the first clock edge at which `enable` is sampled high.
- R3: If `peakLimit` is sampled high while the gate is on, `gateOn` is low after that same clock edge.
- R4: A single on interval never lasts longer than ON_MAX cycles. If `peakLimit` never arrives, the gate is forced low after exactly ON_MAX cycles.
- R5: In timer mode (`fastMode` low), every off interval lasts exactly OFF_MAX cycles, whatever `fluxReset` does.
- R6: In fast-charging mode, an accepted `fluxReset` ends the off interval: `gateOn` rises on the clock edge at which the flag is sampled.
- R7: An off interval counts as valid when an accepted `fluxReset` occurred in it before the timeout. After FAST_ENTRY (default 2) consecutive valid off intervals, `fastMode` goes high on the same edge that starts the next on interval.
- R8: An off interval that ends by timeout with no accepted `fluxReset` clears `fastMode` and restarts the count of consecutive valid intervals.
- R9: `fluxReset` is accepted only once the gate has been low for at least the minimum off pulse. That minimum is MIN_OFF_SHORT cycles when `shortPulseSel` = 1 and MIN_OFF_LONG cycles when `shortPulseSel` = 0. An earlier flag has no effect on the gate or on the mode.
- R10: When `targetReached` is sampled high while enabled, `gateOn` is low after that edge. It stays low, even if the flag drops, until `enable` has been low.
- R11: In fast-charging mode an off interval is still bounded by OFF_MAX cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Charge session enable; low clears all state |
| peakLimit | input | 1 | Primary current has reached its limit |
| fluxReset | input | 1 | Secondary conduction has ended |
| targetReached | input | 1 | Output has reached its target voltage |
| shortPulseSel | input | 1 | 1 selects the short minimum off pulse, 0 the long one |
| gateOn | output | 1 | Power switch gate command |
| fastMode | output | 1 | 1 in fast-charging mode, 0 in timer mode |

## Verification
The assertions assume that `shortPulseSel` stays constant for the whole of any off interval. They also assume that the comparator flags are synchronous to `clk`, so that each flag is sampled once per edge. The bench changes the pulse selection only after `enable` has been low or while the gate is on. It drives the peak and flux flags from a small plant model that reacts to the gate at the ports. Flux pulses are placed exactly at, and one cycle before, each minimum off boundary, so that both the accept and the ignore sides of the rule are exercised.

// File: rtl/flyback_pkg.sv
package flyback_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2,
    PH_DONE = 2'd3
  } fbPhase_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrAll;   // session reset: counters and mode history
    logic clrCnt;   // restart the interval counter
    logic runCnt;   // advance the interval counter
    logic inOff;    // off interval in progress
    logic offDone;  // off interval ends this cycle
  } fbStrobe_t;

endpackage

// File: rtl/fb_datapath.sv
module fb_datapath
  import flyback_pkg::*;
#(
  parameter int ON_MAX        = 1800,
  parameter int OFF_MAX       = 1800,
  parameter int MIN_OFF_SHORT = 20,
  parameter int MIN_OFF_LONG  = 40,
  parameter int FAST_ENTRY    = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  fbStrobe_t strobe,
  input  logic      shortPulseSel,
  input  logic      fluxReset,
  output logic      onExpired,
  output logic      offExpired,
  output logic      fluxOk,
  output logic      fastMode
);

  localparam int CNT_MAX  = (ON_MAX > OFF_MAX) ? ON_MAX : OFF_MAX;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int STREAK_W = $clog2(FAST_ENTRY + 1);

  localparam logic [CNT_W-1:0] ON_LAST   = CNT_W'(ON_MAX - 1);
  localparam logic [CNT_W-1:0] OFF_LAST  = CNT_W'(OFF_MAX - 1);
  localparam logic [CNT_W-1:0] SHORT_TH  = CNT_W'(MIN_OFF_SHORT - 1);
  localparam logic [CNT_W-1:0] LONG_TH   = CNT_W'(MIN_OFF_LONG - 1);
  localparam logic [STREAK_W-1:0] STREAK_TOP = STREAK_W'(FAST_ENTRY);

  logic [CNT_W-1:0]    intervalCnt;
  logic [CNT_W-1:0]    fluxThreshold;
  logic                fluxSeen;
  logic                offValid;
  logic [STREAK_W-1:0] validStreak;
  logic [STREAK_W-1:0] streakNext;

  // Interval counter shared by on and off phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              intervalCnt <= '0;
    else if (strobe.clrAll || strobe.clrCnt) intervalCnt <= '0;
    else if (strobe.runCnt)                 intervalCnt <= intervalCnt + 1'b1;
  end

  assign onExpired     = (intervalCnt == ON_LAST);
  assign offExpired    = (intervalCnt == OFF_LAST);
  assign fluxThreshold = shortPulseSel ? SHORT_TH : LONG_TH;
  assign fluxOk        = fluxReset && (intervalCnt >= fluxThreshold);

  // Remembers an accepted flux reset inside a timer-mode off interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               fluxSeen <= 1'b0;
    else if (strobe.clrAll || strobe.clrCnt) fluxSeen <= 1'b0;
    else if (strobe.inOff && fluxOk)         fluxSeen <= 1'b1;
  end

  assign offValid   = fluxSeen || fluxOk;
  assign streakNext = (validStreak == STREAK_TOP) ? validStreak : validStreak + 1'b1;

  // Consecutive-valid counter and mode flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validStreak <= '0;
      fastMode    <= 1'b0;
    end else if (strobe.clrAll) begin
      validStreak <= '0;
      fastMode    <= 1'b0;
    end else if (strobe.offDone) begin
      if (offValid) begin
        validStreak <= streakNext;
        fastMode    <= (streakNext >= STREAK_TOP);
      end else begin
        validStreak <= '0;
        fastMode    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fb_control.sv
module fb_control
  import flyback_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      peakLimit,
  input  logic      targetReached,
  input  logic      onExpired,
  input  logic      offExpired,
  input  logic      fluxOk,
  input  logic      fastMode,
  output fbStrobe_t strobe,
  output logic      gateOn
);

  fbPhase_t phase;
  fbPhase_t phaseNext;
  logic     offEnds;

  assign offEnds = (fastMode && fluxOk) || offExpired;

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    if (!enable) begin
      phaseNext     = PH_IDLE;
      strobe.clrAll = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          strobe.clrCnt = 1'b1;
          phaseNext     = targetReached ? PH_DONE : PH_ON;
        end
        PH_ON: begin
          strobe.runCnt = 1'b1;
          if (targetReached) begin
            phaseNext = PH_DONE;
          end else if (peakLimit || onExpired) begin
            phaseNext     = PH_OFF;
            strobe.clrCnt = 1'b1;
          end
        end
        PH_OFF: begin
          strobe.runCnt = 1'b1;
          strobe.inOff  = 1'b1;
          if (targetReached) begin
            phaseNext = PH_DONE;
          end else if (offEnds) begin
            phaseNext      = PH_ON;
            strobe.clrCnt  = 1'b1;
            strobe.offDone = 1'b1;
          end
        end
        default: phaseNext = PH_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign gateOn = (phase == PH_ON);

endmodule

// File: rtl/flyback_cycle_ctrl.sv
module flyback_cycle_ctrl
  import flyback_pkg::*;
#(
  parameter int ON_MAX        = 1800,
  parameter int OFF_MAX       = 1800,
  parameter int MIN_OFF_SHORT = 20,
  parameter int MIN_OFF_LONG  = 40,
  parameter int FAST_ENTRY    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic peakLimit,
  input  logic fluxReset,
  input  logic targetReached,
  input  logic shortPulseSel,
  output logic gateOn,
  output logic fastMode
);

  fbStrobe_t strobe;
  logic      onExpired;
  logic      offExpired;
  logic      fluxOk;

  fb_control i_control (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .peakLimit     (peakLimit),
    .targetReached (targetReached),
    .onExpired     (onExpired),
    .offExpired    (offExpired),
    .fluxOk        (fluxOk),
    .fastMode      (fastMode),
    .strobe        (strobe),
    .gateOn        (gateOn)
  );

  fb_datapath #(
    .ON_MAX        (ON_MAX),
    .OFF_MAX       (OFF_MAX),
    .MIN_OFF_SHORT (MIN_OFF_SHORT),
    .MIN_OFF_LONG  (MIN_OFF_LONG),
    .FAST_ENTRY    (FAST_ENTRY)
  ) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .shortPulseSel (shortPulseSel),
    .fluxReset     (fluxReset),
    .onExpired     (onExpired),
    .offExpired    (offExpired),
    .fluxOk        (fluxOk),
    .fastMode      (fastMode)
  );

endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
  parameter int ON_MAX        = 1800,
  parameter int OFF_MAX       = 1800,
  parameter int MIN_OFF_SHORT = 20
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic peakLimit,
  input logic targetReached,
  input logic gateOn,
  input logic fastMode
);

  localparam int RUN_W = $clog2(((ON_MAX > OFF_MAX) ? ON_MAX : OFF_MAX) + 2);
  localparam logic [RUN_W-1:0] RUN_TOP = {RUN_W{1'b1}};

  logic [RUN_W-1:0] onRun;
  logic [RUN_W-1:0] offRun;
  logic             wasOn;
  logic             doneSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onRun    <= '0;
      offRun   <= '0;
      wasOn    <= 1'b0;
      doneSeen <= 1'b0;
    end else if (!enable) begin
      onRun    <= '0;
      offRun   <= '0;
      wasOn    <= 1'b0;
      doneSeen <= 1'b0;
    end else begin
      onRun    <= gateOn ? ((onRun == RUN_TOP) ? onRun : onRun + 1'b1) : '0;
      offRun   <= gateOn ? '0 : ((offRun == RUN_TOP) ? offRun : offRun + 1'b1);
      wasOn    <= wasOn || gateOn;
      doneSeen <= doneSeen || targetReached;
    end
  end

  assert_enable_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!gateOn && !fastMode));

  assert_peak_cuts_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && gateOn && peakLimit) |=> !gateOn);

  assert_on_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    gateOn |-> (onRun < RUN_W'(ON_MAX)));

  assert_off_bounded_R11: assert property (@(posedge clk) disable iff (!rstN)
    (enable && wasOn && !doneSeen && !gateOn) |-> (offRun < RUN_W'(OFF_MAX)));

  assert_mode_at_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fastMode) |-> $rose(gateOn));

  assert_min_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(gateOn) && wasOn) |-> (offRun >= RUN_W'(MIN_OFF_SHORT)));

  assert_target_stops_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |-> !gateOn);

endmodule

bind flyback_cycle_ctrl fb_checker #(
  .ON_MAX        (ON_MAX),
  .OFF_MAX       (OFF_MAX),
  .MIN_OFF_SHORT (MIN_OFF_SHORT)
) i_fb_checker (
  .clk           (clk),
  .rstN          (rstN),
  .enable        (enable),
  .peakLimit     (peakLimit),
  .targetReached (targetReached),
  .gateOn        (gateOn),
  .fastMode      (fastMode)
);

// File: tb/test_flyback_cycle_ctrl.sv
module test_flyback_cycle_ctrl;

  localparam int ON_MAX  = 50;
  localparam int OFF_MAX = 60;
  localparam int MIN_S   = 4;
  localparam int MIN_L   = 8;
  localparam int ENTRY   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic peakLimit = 1'b0;
  logic fluxReset = 1'b0;
  logic targetReached = 1'b0;
  logic shortPulseSel = 1'b1;
  logic gateOn;
  logic fastMode;

  always #2 clk = ~clk;

  flyback_cycle_ctrl #(
    .ON_MAX(ON_MAX), .OFF_MAX(OFF_MAX), .MIN_OFF_SHORT(MIN_S),
    .MIN_OFF_LONG(MIN_L), .FAST_ENTRY(ENTRY)
  ) i_flyback_cycle_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .peakLimit(peakLimit),
    .fluxReset(fluxReset), .targetReached(targetReached),
    .shortPulseSel(shortPulseSel), .gateOn(gateOn), .fastMode(fastMode)
  );

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model: phase 0 idle, 1 on, 2 off, 3 done
  int  mPhase = 0, mLen = 0, mStreak = 0;
  bit  mSeen = 0, mFast = 0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN || !enable) begin
      mPhase = 0; mLen = 0; mSeen = 0; mStreak = 0; mFast = 0;
    end else if (mPhase == 0) begin
      mPhase = targetReached ? 3 : 1;
      mLen = 1;
    end else if (mPhase == 1) begin
      if (targetReached) mPhase = 3;
      else if (peakLimit || mLen >= ON_MAX) begin mPhase = 2; mLen = 1; mSeen = 0; end
      else mLen++;
    end else if (mPhase == 2) begin
      automatic bit okFlux = fluxReset && (mLen >= (shortPulseSel ? MIN_S : MIN_L));
      if (targetReached) mPhase = 3;
      else if ((mFast && okFlux) || mLen >= OFF_MAX) begin
        if (mSeen || okFlux) begin
          mStreak = (mStreak + 1 > ENTRY) ? ENTRY : mStreak + 1;
          mFast = (mStreak >= ENTRY);
        end else begin
          mStreak = 0; mFast = 0;
        end
        mPhase = 1; mLen = 1; mSeen = 0;
      end else begin
        if (okFlux) mSeen = 1;
        mLen++;
      end
    end
  end

  // Plant: peak after pkDelay high samples, one-cycle flux pulse after fxDelay low samples
  bit pkEn = 0, fxEn = 0;
  int pkDelay = 10, fxDelay = 4;
  int hiCnt = 0, loCnt = 0, lastOnLen = 0, lastOffLen = 0;
  bit sawHigh = 0;

  task automatic step();
    @(negedge clk);
    check(gateOn === (mPhase == 1), {curReq, " gate"}, gateOn, (mPhase == 1));
    check(fastMode === mFast, {curReq, " mode"}, fastMode, mFast);
    if (gateOn) begin
      if (hiCnt == 0 && loCnt > 0) lastOffLen = loCnt;
      hiCnt++; loCnt = 0; sawHigh = 1;
    end else begin
      if (hiCnt > 0) lastOnLen = hiCnt;
      hiCnt = 0; loCnt++;
    end
    peakLimit = pkEn && gateOn && (hiCnt >= pkDelay);
    fluxReset = fxEn && !gateOn && (loCnt == fxDelay);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic restart();
    enable = 1'b0; peakLimit = 1'b0; fluxReset = 1'b0;
    run(3);
    hiCnt = 0; loCnt = 0; lastOnLen = 0; lastOffLen = 0;
    enable = 1'b1;
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    run(2);
    check(gateOn == 0 && fastMode == 0, "R1 reset", {gateOn, fastMode}, 0);

    // R2 start, R4 on watchdog, R5 timer off
    curReq = "R2"; enable = 1'b1;
    step();
    check(gateOn == 1, "R2 start edge", gateOn, 1);
    curReq = "R4"; fxEn = 1; fxDelay = 4;
    run(150);
    check(lastOnLen == ON_MAX, "R4 on length", lastOnLen, ON_MAX);
    check(lastOffLen == OFF_MAX, "R5 timer off length", lastOffLen, OFF_MAX);

    // R3 peak, R7 entry, R6 fast restart at min pulse (short)
    curReq = "R7"; restart(); pkEn = 1; pkDelay = 10; shortPulseSel = 1;
    run(250);
    check(lastOnLen == 10, "R3 peak cut", lastOnLen, 10);
    check(fastMode == 1, "R7 fast entry", fastMode, 1);
    check(lastOffLen == MIN_S, "R6 fast off length", lastOffLen, MIN_S);

    // R9 early flux ignored, R8 timeout leaves fast mode
    curReq = "R9"; fxDelay = MIN_S - 1;
    run(200);
    check(fastMode == 0, "R8 timeout clears mode", fastMode, 0);
    check(lastOffLen == OFF_MAX, "R9 early flux ignored", lastOffLen, OFF_MAX);

    // R9 long minimum pulse
    curReq = "R9"; restart(); shortPulseSel = 0; fxDelay = MIN_L - 1;
    run(300);
    check(fastMode == 0, "R9 long min, early flux", fastMode, 0);
    curReq = "R6"; restart(); fxDelay = MIN_L;
    run(300);
    check(fastMode == 1, "R7 fast entry long", fastMode, 1);
    check(lastOffLen == MIN_L, "R6 long min accepted", lastOffLen, MIN_L);

    // R11 fast off bounded, then back to timer
    curReq = "R11"; fxEn = 0;
    run(100);
    check(lastOffLen == OFF_MAX, "R11 fast off bounded", lastOffLen, OFF_MAX);
    check(fastMode == 0, "R8 mode cleared", fastMode, 0);

    // R10 target stops switching until enable cycles
    curReq = "R10"; fxEn = 1;
    while (!gateOn) step();
    targetReached = 1'b1;
    step();
    check(gateOn == 0, "R10 target cuts gate", gateOn, 0);
    targetReached = 1'b0; sawHigh = 0;
    run(150);
    check(sawHigh == 0, "R10 stays stopped", sawHigh, 0);

    // R1 enable low in fast mode, restart in timer mode
    curReq = "R1"; restart(); shortPulseSel = 1; fxDelay = MIN_S;
    run(250);
    check(fastMode == 1, "R1 pre fast", fastMode, 1);
    enable = 1'b0;
    step();
    check(gateOn == 0 && fastMode == 0, "R1 enable low", {gateOn, fastMode}, 0);
    run(3);
    enable = 1'b1;
    run(80);
    check(fastMode == 0, "R1 restarts timer mode", fastMode, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule